// File: doc/BRIEF.md
# Black-Level Clamp Correction Loop

This block closes a digital feedback loop around an image sensor's black level. On each line the sensor delivers a run of shielded pixels, and a timing input marks that run as the black window. Inside the window the block compares each valid 10-bit ADC sample with a programmable target black level. It averages the error over the window and, when the window closes, folds a scaled-down share of that average into a signed correction code. The code drives an offset DAC ahead of the converter. Repeating this line after line pulls the digitised black level onto the target.

The target is given in quarter-LSB steps, so an 8-bit value spans 0 to 63.75 LSB. Software can slow the loop so that only every Nth qualifying window produces an update. It can also freeze the loop, in which case the target value itself goes out as a fixed offset code. Windows that are too short carry too little information and are discarded.

Top module: `blc_clamp_loop`

## Requirements
- R1: After reset, with `loop_en` high, `dac_code` is 0 and the line counter is cleared.
- R2: The per-sample error in quarter-LSB units is `black_ref - 4*adc_data`, where `black_ref` LSB 0 weighs 0.25 LSB. The correction changes only on the clock edge where `clamp_win` is seen low after being high (window close). At any other time `dac_code` is steady, including while the window is still open.
- R3: A sample is accepted only when `clamp_win` and `sample_valid` are both high. Any other sample has no effect on the correction.
- R4: A window with fewer than 2 accepted samples leaves the correction and the line counter unchanged.
- R5: The window average is the floor of the mean error over its first 2^j accepted samples, where 2^j is the largest power of two not above min(count, 2^AVG_LOG). With the default AVG_LOG=4, samples after the 16th are ignored.
- R6: When a window is applied, the correction grows by the window average arithmetically shifted right by K (default 1). It rises when samples lie below the target.
- R7: A window is applied only when it is the (`upd_lines`+1)-th qualifying window since the last application. The averages of the skipped windows are discarded.
- R8: The correction is a 12-bit two's complement code that saturates at +2047 and -2048 instead of wrapping.
- R9: While `loop_en` is low, `dac_code` equals `black_ref` zero-extended, the correction is held, windows are ignored and the line counter is cleared. Raising `loop_en` again restores the held correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | 1 runs the loop, 0 freezes it and outputs the target as a fixed offset |
| black_ref | input | 8 | Target black level in quarter-LSB units |
| upd_lines | input | 4 | Qualifying windows skipped between updates |
| clamp_win | input | 1 | High during the shielded black pixels of a line |
| sample_valid | input | 1 | ADC sample strobe |
| adc_data | input | 10 | ADC output sample |
| dac_code | output | 12 | Signed correction code to the offset DAC |

## Verification
The properties assume that `clamp_win` is a clean level that falls exactly once per window. They also assume that the correction is read only through `dac_code` and its internal register, and that a close happens in a cycle with no accepted sample, which follows from the acceptance rule itself. The stimulus changes every input on the falling clock edge. It holds `clamp_win` high for whole windows followed by at least one low cycle, and it changes `upd_lines` only directly after an applied update. Because of this, the qualifying-window count the bench keeps matches the block's.

// File: rtl/blc_pkg.sv
package blc_pkg;

    // Index of a power of two, or -1 when the value is not one.
    function automatic int pow2_index(input int unsigned value, input int max_log);
        int idx;
        idx = -1;
        for (int i = 0; i <= max_log; i++) begin
            if (value == (32'd1 << i)) idx = i;
        end
        return idx;
    endfunction

    // Minimum accepted samples for a window to count.
    localparam int unsigned MIN_WIN_SAMPLES = 2;

endpackage

// File: rtl/blc_accum.sv
module blc_accum #(
    parameter int ADC_W   = 10,
    parameter int REF_W   = 8,
    parameter int FRAC    = 2,
    parameter int AVG_LOG = 4,
    localparam int E_W    = ADC_W + FRAC + 1,
    localparam int C_W    = AVG_LOG + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    take,
    input  logic [ADC_W-1:0]        adc,
    input  logic [REF_W-1:0]        target,
    output logic signed [E_W-1:0]   avg,
    output logic [C_W-1:0]          cnt
);
    import blc_pkg::*;

    localparam int S_W = E_W + AVG_LOG;
    localparam logic [C_W-1:0] CAP = C_W'(1) << AVG_LOG;

    typedef struct packed {
        logic signed [S_W-1:0] sum;
        logic [C_W-1:0]        cnt;
        logic signed [E_W-1:0] avg;
    } acc_t;

    acc_t acc_d, acc_q;
    logic signed [E_W-1:0] err;
    logic signed [S_W-1:0] sum_n;
    logic [C_W-1:0]        cnt_n;

    always_comb begin
        acc_d = acc_q;
        err   = $signed({{(E_W-REF_W){1'b0}}, target}) - $signed({1'b0, adc, {FRAC{1'b0}}});
        sum_n = acc_q.sum + S_W'(err);
        cnt_n = acc_q.cnt + 1'b1;
        if (clear) begin
            acc_d = '0;
        end else if (take && acc_q.cnt < CAP) begin
            acc_d.sum = sum_n;
            acc_d.cnt = cnt_n;
            for (int i = 0; i <= AVG_LOG; i++) begin
                if (pow2_index(int'(cnt_n), AVG_LOG) == i) acc_d.avg = E_W'(sum_n >>> i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign avg = acc_q.avg;
    assign cnt = acc_q.cnt;
endmodule

// File: rtl/blc_update.sv
module blc_update #(
    parameter int CORR_W = 12,
    parameter int E_W    = 13,
    parameter int K      = 1,
    parameter int LINE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     close,
    input  logic                     qualified,
    input  logic signed [E_W-1:0]    avg,
    input  logic [LINE_W-1:0]        upd_lines,
    output logic signed [CORR_W-1:0] corr
);
    localparam int SUM_W = ((E_W > CORR_W) ? E_W : CORR_W) + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((64'sd1 <<< (CORR_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -HI - 1;

    typedef struct packed {
        logic signed [CORR_W-1:0] corr;
        logic [LINE_W-1:0]        lines;
    } upd_t;

    upd_t upd_d, upd_q;
    logic signed [E_W-1:0]   step;
    logic signed [SUM_W-1:0] total;

    always_comb begin
        upd_d = upd_q;
        step  = avg >>> K;
        total = SUM_W'(upd_q.corr) + SUM_W'(step);
        if (!en) begin
            upd_d.lines = '0;
        end else if (close && qualified) begin
            if (upd_q.lines == upd_lines) begin
                upd_d.lines = '0;
                if (total > HI)      upd_d.corr = CORR_W'(HI);
                else if (total < LO) upd_d.corr = CORR_W'(LO);
                else                 upd_d.corr = CORR_W'(total);
            end else begin
                upd_d.lines = upd_q.lines + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= '0;
        else        upd_q <= upd_d;
    end

    assign corr = upd_q.corr;
endmodule

// File: rtl/blc_clamp_loop.sv
module blc_clamp_loop #(
    parameter int ADC_W   = 10,
    parameter int REF_W   = 8,
    parameter int FRAC    = 2,
    parameter int AVG_LOG = 4,
    parameter int CORR_W  = 12,
    parameter int K       = 1,
    parameter int LINE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic [REF_W-1:0]  black_ref,
    input  logic [LINE_W-1:0] upd_lines,
    input  logic              clamp_win,
    input  logic              sample_valid,
    input  logic [ADC_W-1:0]  adc_data,
    output logic [CORR_W-1:0] dac_code
);
    import blc_pkg::*;

    localparam int E_W = ADC_W + FRAC + 1;
    localparam int C_W = AVG_LOG + 1;

    typedef struct packed {
        logic win;
    } top_t;

    top_t top_d, top_q;
    logic close, take, clear, qualified;
    logic signed [E_W-1:0]    avg;
    logic [C_W-1:0]           cnt;
    logic signed [CORR_W-1:0] corr_q;

    always_comb begin
        top_d.win = clamp_win;
        close     = top_q.win & ~clamp_win;
        take      = loop_en & clamp_win & sample_valid;
        clear     = close | ~loop_en;
        qualified = (int'(cnt) >= int'(MIN_WIN_SAMPLES));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    blc_accum #(.ADC_W(ADC_W), .REF_W(REF_W), .FRAC(FRAC), .AVG_LOG(AVG_LOG)) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(clear), .take(take),
        .adc(adc_data), .target(black_ref), .avg(avg), .cnt(cnt)
    );

    blc_update #(.CORR_W(CORR_W), .E_W(E_W), .K(K), .LINE_W(LINE_W)) u_update (
        .clk(clk), .rst_n(rst_n), .en(loop_en), .close(close), .qualified(qualified),
        .avg(avg), .upd_lines(upd_lines), .corr(corr_q)
    );

    generate
        if (CORR_W > REF_W) begin : g_wide
            assign dac_code = loop_en ? corr_q : {{(CORR_W-REF_W){1'b0}}, black_ref};
        end else begin : g_narrow
            assign dac_code = loop_en ? corr_q : black_ref[CORR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/blc_clamp_loop_chk.sv
module blc_clamp_loop_chk #(
    parameter int CORR_W  = 12,
    parameter int AVG_LOG = 4,
    parameter int E_W     = 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     loop_en,
    input logic                     clamp_win,
    input logic signed [CORR_W-1:0] corr_q,
    input logic [AVG_LOG:0]         cnt,
    input logic signed [E_W-1:0]    avg
);
    localparam logic signed [CORR_W-1:0] HI = {1'b0, {(CORR_W-1){1'b1}}};
    localparam int CAP = 1 << AVG_LOG;

    logic win_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_prev <= 1'b0;
        else        win_prev <= clamp_win;
    end

    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> $stable(corr_q));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_prev && !clamp_win) |=> $stable(corr_q));

    p_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_prev && !clamp_win && int'(cnt) < 2) |=> $stable(corr_q));

    p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= CAP);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_prev && !clamp_win) |=> (cnt == '0));

    p_sat_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_prev && !clamp_win && loop_en && corr_q == HI && !avg[E_W-1]) |=> (corr_q == HI));
endmodule

bind blc_clamp_loop blc_clamp_loop_chk #(.CORR_W(CORR_W), .AVG_LOG(AVG_LOG), .E_W(E_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .clamp_win(clamp_win),
    .corr_q(corr_q), .cnt(cnt), .avg(avg)
);

// File: tb/blc_clamp_loop_test.sv
module blc_clamp_loop_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loop_en = 1'b1;
    logic [7:0]  black_ref = 8'd128;
    logic [3:0]  upd_lines = 4'd0;
    logic        clamp_win = 1'b0;
    logic        sample_valid = 1'b0;
    logic [9:0]  adc_data = '0;
    logic [11:0] dac_code;

    int checks = 0;
    int errors = 0;
    int exp_corr = 0;
    int lines_seen = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    blc_clamp_loop uut (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .black_ref(black_ref),
        .upd_lines(upd_lines), .clamp_win(clamp_win), .sample_valid(sample_valid),
        .adc_data(adc_data), .dac_code(dac_code)
    );

    function automatic int sat12(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int prefix_avg(input int n1, input int v1, input int n2, input int v2, input int r);
        int m, p, lg, s;
        m = n1 + n2;
        if (m > 16) m = 16;
        p = 1; lg = 0;
        while (p * 2 <= m) begin p = p * 2; lg++; end
        s = 0;
        for (int i = 0; i < p; i++) s += r - 4 * ((i < n1) ? v1 : v2);
        return s >>> lg;
    endfunction

    function automatic logic [11:0] exp_out();
        if (loop_en) return exp_corr[11:0];
        return {4'b0, black_ref};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dac_code=%0d expected=%0d", req, $signed(act), $signed(exp));
        end
    endtask

    // Drives a window of n1 samples of v1 then n2 of v2, then closes it.
    task automatic window(input int n1, input int v1, input int n2, input int v2, input string req);
        int a;
        for (int i = 0; i < n1 + n2; i++) begin
            @(negedge clk);
            clamp_win = 1'b1; sample_valid = 1'b1;
            adc_data = 10'((i < n1) ? v1 : v2);
        end
        @(negedge clk);
        check({req, " open window keeps code (R2)"}, dac_code, exp_out());
        clamp_win = 1'b0; sample_valid = 1'b0;
        if (loop_en && n1 + n2 >= 2) begin
            if (lines_seen == int'(upd_lines)) begin
                lines_seen = 0;
                a = prefix_avg(n1, v1, n2, v2, int'(black_ref));
                exp_corr = sat12(exp_corr + (a >>> 1));
            end else begin
                lines_seen++;
            end
        end
        @(negedge clk);
        check(req, dac_code, exp_out());
    endtask

    task automatic t_reset();
        check("R1 reset code", dac_code, 12'd0);
    endtask

    task automatic t_basic();
        black_ref = 8'd128;
        window(20, 20, 0, 0, "R2 R6 below target");
        check("R6 step value 24", dac_code, 12'd24);
        window(20, 40, 0, 0, "R6 above target");
        check("R6 step back to 8", dac_code, 12'd8);
    endtask

    task automatic t_outside();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            clamp_win = 1'b0; sample_valid = 1'b1; adc_data = 10'd0;
        end
        @(negedge clk);
        sample_valid = 1'b0;
        check("R3 samples outside window", dac_code, exp_out());
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            clamp_win = 1'b1;
            sample_valid = i[0];
            adc_data = i[0] ? 10'd32 : 10'd0;
        end
        @(negedge clk);
        clamp_win = 1'b0; sample_valid = 1'b0;
        @(negedge clk);
        check("R3 invalid strobes ignored", dac_code, exp_out());
    endtask

    task automatic t_short();
        window(1, 0, 0, 0, "R4 single-sample window");
        window(2, 10, 0, 0, "R4 two-sample window");
        check("R4 two samples step 44", dac_code, 12'd52);
    endtask

    task automatic t_average();
        window(2, 0, 2, 32, "R5 mixed four samples");
        window(4, 30, 1, 0, "R5 fifth sample outside prefix");
        window(16, 32, 10, 0, "R5 samples past cap ignored");
    endtask

    task automatic t_rate();
        upd_lines = 4'd2;
        window(6, 0, 0, 0, "R7 skipped window 1");
        window(1, 0, 0, 0, "R7 short window not counted");
        window(6, 0, 0, 0, "R7 skipped window 2");
        window(6, 31, 0, 0, "R7 applied window");
        upd_lines = 4'd0;
    endtask

    task automatic t_sat();
        black_ref = 8'd255;
        for (int i = 0; i < 20; i++) window(2, 0, 0, 0, "R8 climb");
        check("R8 high limit", dac_code, 12'd2047);
        window(2, 0, 0, 0, "R8 stays at high limit");
        black_ref = 8'd0;
        for (int i = 0; i < 3; i++) window(2, 1023, 0, 0, "R8 fall");
        check("R8 low limit", dac_code, 12'h800);
        window(4, 1023, 0, 0, "R8 stays at low limit");
    endtask

    task automatic t_disable();
        black_ref = 8'd128;
        window(4, 0, 0, 0, "R9 before freeze");
        @(negedge clk);
        loop_en = 1'b0; black_ref = 8'd100;
        @(negedge clk);
        check("R9 fixed offset", dac_code, 12'd100);
        black_ref = 8'd7;
        @(negedge clk);
        check("R9 follows target", dac_code, 12'd7);
        window(8, 0, 0, 0, "R9 window while frozen");
        loop_en = 1'b1;
        @(negedge clk);
        check("R9 held correction restored", dac_code, exp_corr[11:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_outside();
        t_short();
        t_average();
        t_rate();
        t_sat();
        t_disable();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule